// File: doc/BRIEF.md
# Temperature Softmax Token Sampler

This block picks one token index out of a vocabulary of fixed-point logits. On a start pulse it reads the logits one per cycle through a small asynchronous read port. It then produces an index in one of two ways. In greedy mode it returns the position of the largest logit. In sampling mode it multiplies every logit by an inverse temperature and turns the results into unnormalised softmax weights. It then draws an index at random, with each index chosen in proportion to its weight.

The weights come from a piecewise-linear base-2 exponential. The largest scaled logit is subtracted first, so every exponent argument is zero or negative and the top weight is always exactly one. A 32-bit linear congruential generator supplies the randomness. Selection uses no divider: the upper random bits are multiplied by the weight total, and a second walk over the weights finds the first index whose running sum exceeds that threshold. The generator can be seeded at any time. One start yields one done pulse with a valid index.

Top module: `tok_sampler`

## Requirements
- R1: After reset, `done` is low and `token` is 0, and the generator state is 0.
- R2: With `greedy` high at start, the result is the index of the largest logit. Logits are signed 16-bit values with 11 fractional bits.
- R3: In greedy mode, equal largest logits resolve to the lowest index.
- R4: In sampling mode, each logit is scaled as floor(logit × inv_temp / 2048). Here inv_temp is an unsigned 16-bit value with 11 fractional bits. The largest scaled value is subtracted from each one, so every exponent argument is ≤ 0.
- R5: For an argument d ≤ 0, the weight is computed as follows. Clamp d to at least -32768. Let y = floor(-d × 2955 / 2048), n = floor(y / 2048) and f = y mod 2048. The weight is 0 if n ≥ 16, otherwise floor((32768 − 8f) / 2ⁿ). Weights are therefore at most 32768, and inv_temp = 0 gives equal weights.
- R6: The weight total is accumulated over all 27 entries at 21 bits, without overflow.
- R7: The generator computes s ← s × 1664525 + 1013904223 modulo 2³². A high `seed_load` in an idle or busy cycle writes `seed` into the state.
- R8: The generator advances exactly once per sampling run and never during a greedy run.
- R9: The threshold is floor(r × total / 65536), where r is bits 31:16 of the advanced state. The result is the first index whose cumulative weight is strictly greater than the threshold, so zero-weight entries are never chosen.
- R10: `done` is a one-cycle pulse, and `token` holds its value until the next pulse. A greedy run raises `done` right after the 27th rising edge following the edge that accepts start.
- R11: `start` is ignored while a run is in progress. Mode and inverse temperature are captured when start is accepted.
- R12: The draw happens on the 55th rising edge after the edge that accepts start. If `seed_load` is high on that edge, the loaded seed is advanced once and used for the draw.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run when idle |
| greedy | input | 1 | 1: argmax, 0: temperature sampling |
| inv_temp | input | 16 | Inverse temperature, unsigned, 11 fractional bits |
| seed_load | input | 1 | Write `seed` into the generator |
| seed | input | 32 | Generator seed value |
| rd_addr | output | 5 | Logit read address |
| rd_data | input | 16 | Logit at `rd_addr`, same cycle |
| done | output | 1 | One-cycle result strobe |
| token | output | 5 | Selected index |

## Verification
A seed write and the generator's draw step can both land on the same rising edge. The bench provokes this by raising `seed_load` in exactly the cycle before the 55th edge after start acceptance. It then judges the token against a model that advances from the freshly loaded seed, not from the old state. The sample that follows must continue from the state produced by that combined step, which confirms that neither the load nor the advance was lost.

// File: rtl/tok_sampler_pkg.sv
package tok_sampler_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_SCAN,
      PH_SUM,
      PH_DRAW,
      PH_PICK
   } phase_t;

   localparam logic [31:0] LCG_MUL = 32'd1664525;
   localparam logic [31:0] LCG_INC = 32'd1013904223;
endpackage

// File: rtl/tok_lcg.sv
module tok_lcg
   import tok_sampler_pkg::*;
#(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] seed,
   input  logic         step,
   output logic [W-1:0] draw
);
   if (W != 32) begin : g_bad_width
      $error("tok_lcg: constants are defined modulo 2^32");
   end

   logic [W-1:0] st_q;
   logic [W-1:0] src;

   // a load in the stepping cycle is applied first, then advanced
   assign src  = load ? seed : st_q;
   assign draw = src * LCG_MUL + LCG_INC;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     st_q <= '0;
      else if (step)  st_q <= draw;
      else if (load)  st_q <= seed;
   end

   // R7/R8: the state moves only on a load or a draw
   a_r8_state_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !step) |=> $stable(st_q));
   // R7: a plain load lands unchanged
   a_r7_seed_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !step) |=> (st_q == $past(seed)));
endmodule

// File: rtl/tok_scale.sv
module tok_scale #(
   parameter int DW   = 16,
   parameter int FRAC = 11,
   parameter int SW   = 24
) (
   input  logic signed [DW-1:0] logit,
   input  logic        [DW-1:0] inv_temp,
   output logic signed [SW-1:0] scaled
);
   localparam int PW = 2 * DW + 1;

   if (SW < PW - FRAC || SW > PW) begin : g_bad_sw
      $error("tok_scale: SW must hold the shifted product");
   end

   logic signed [PW-1:0] a_x, b_x, prod, sh;
   logic                 unused_sh;

   assign a_x  = {{(DW + 1){logit[DW-1]}}, logit};
   assign b_x  = {{(DW + 1){1'b0}}, inv_temp};
   assign prod = a_x * b_x;
   assign sh   = prod >>> FRAC;

   assign scaled    = sh[SW-1:0];
   assign unused_sh = ^sh[PW-1:SW-1];
endmodule

// File: rtl/tok_pwl_exp.sv
module tok_pwl_exp #(
   parameter int SW   = 24,
   parameter int FRAC = 11,
   parameter int WW   = 16
) (
   input  logic signed [SW-1:0] arg,
   output logic        [WW-1:0] weight
);
   localparam int          MW      = FRAC + 6;
   localparam longint      LOG2E_L = (64'd94548 * (64'd1 << FRAC) + 64'd32768) >> 16;
   localparam logic [31:0] LOG2E   = 32'(LOG2E_L);
   localparam int          SHL     = WW - 2 - FRAC;

   if (SHL < 0) begin : g_bad_ww
      $error("tok_pwl_exp: WW too narrow for fraction");
   end
   if (SW < MW + 1) begin : g_bad_sw
      $error("tok_pwl_exp: SW must hold the clamp bound");
   end

   localparam logic signed [SW-1:0] FLOOR = -(SW'(1) <<< (FRAC + 4));
   localparam logic [WW-1:0]        ONE   = WW'(1) << (WW - 1);

   logic signed [SW-1:0] dc, neg;
   logic [MW-1:0]        mag;
   logic [31:0]          y;
   logic [31-FRAC:0]     oct;
   logic [FRAC-1:0]      fr;
   logic [WW-1:0]        mant;
   logic                 unused_neg;

   assign dc   = (arg < FLOOR) ? FLOOR : arg;
   assign neg  = -dc;
   assign mag  = neg[MW-1:0];
   assign y    = ({{(32 - MW){1'b0}}, mag} * LOG2E) >> FRAC;
   assign oct  = y[31:FRAC];
   assign fr   = y[FRAC-1:0];
   // chord of 2^-x across one octave: 1 at x=0, 1/2 at x=1
   assign mant = ONE - (WW'(fr) << SHL);

   assign weight     = (oct >= (32 - FRAC)'(WW)) ? '0 : (mant >> oct);
   assign unused_neg = ^neg[SW-1:MW];
endmodule

// File: rtl/tok_sampler.sv
module tok_sampler
   import tok_sampler_pkg::*;
#(
   parameter int N     = 27,
   parameter int DW    = 16,
   parameter int FRAC  = 11,
   parameter int SW    = 24,
   parameter int WW    = 16,
   parameter int RND_W = 16,
   parameter int IW    = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          greedy,
   input  logic [DW-1:0] inv_temp,
   input  logic          seed_load,
   input  logic [31:0]   seed,
   output logic [IW-1:0] rd_addr,
   input  logic [DW-1:0] rd_data,
   output logic          done,
   output logic [IW-1:0] token
);
   localparam int            SUMW = WW + $clog2(N);
   localparam int            PW   = RND_W + SUMW;
   localparam logic [IW-1:0] LAST = IW'(N - 1);
   localparam logic [WW-1:0] ONE  = WW'(1) << (WW - 1);

   if (N < 2 || N > (1 << IW)) begin : g_bad_n
      $error("tok_sampler: N must fit the index width");
   end
   if (RND_W > 32) begin : g_bad_rnd
      $error("tok_sampler: RND_W exceeds generator width");
   end

   phase_t               phase;
   logic [IW-1:0]        idx, best_idx, token_q;
   logic signed [DW-1:0] best_raw, logit;
   logic signed [SW-1:0] max_sc, scaled, arg;
   logic [DW-1:0]        temp_q;
   logic                 greedy_q, done_q;
   logic [SUMW-1:0]      sum_q, cum_q, thr_q, cum_n, thr;
   logic [WW-1:0]        w;
   logic [31:0]          lcg_draw;
   logic [PW-1:0]        thr_prod;
   logic                 at_last, raw_upd, sc_upd;
   logic                 unused_lo;

   assign logit   = $signed(rd_data);
   assign rd_addr = idx;
   assign at_last = (idx == LAST);
   assign raw_upd = (idx == '0) || (logit > best_raw);
   assign sc_upd  = (idx == '0) || (scaled > max_sc);
   assign arg     = scaled - max_sc;
   assign cum_n   = cum_q + SUMW'(w);

   tok_scale #(.DW(DW), .FRAC(FRAC), .SW(SW)) u_scale (
      .logit(logit), .inv_temp(temp_q), .scaled(scaled));

   tok_pwl_exp #(.SW(SW), .FRAC(FRAC), .WW(WW)) u_exp (
      .arg(arg), .weight(w));

   tok_lcg #(.W(32)) u_lcg (
      .clk(clk), .rst_n(rst_n), .load(seed_load), .seed(seed),
      .step(phase == PH_DRAW), .draw(lcg_draw));

   assign thr_prod  = PW'(lcg_draw[31:32-RND_W]) * PW'(sum_q);
   assign thr       = thr_prod[PW-1:RND_W];
   assign unused_lo = ^{thr_prod[RND_W-1:0], lcg_draw[31-RND_W:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         idx      <= '0;
         best_idx <= '0;
         best_raw <= '0;
         max_sc   <= '0;
         temp_q   <= '0;
         greedy_q <= 1'b0;
         sum_q    <= '0;
         cum_q    <= '0;
         thr_q    <= '0;
         done_q   <= 1'b0;
         token_q  <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (phase)
            PH_IDLE: if (start) begin
               phase    <= PH_SCAN;
               idx      <= '0;
               greedy_q <= greedy;
               temp_q   <= inv_temp;
            end
            PH_SCAN: begin
               if (raw_upd) begin
                  best_raw <= logit;
                  best_idx <= idx;
               end
               if (sc_upd) max_sc <= scaled;
               if (at_last) begin
                  idx   <= '0;
                  sum_q <= '0;
                  if (greedy_q) begin
                     token_q <= raw_upd ? idx : best_idx;
                     done_q  <= 1'b1;
                     phase   <= PH_IDLE;
                  end else begin
                     phase <= PH_SUM;
                  end
               end else begin
                  idx <= idx + IW'(1);
               end
            end
            PH_SUM: begin
               sum_q <= sum_q + SUMW'(w);
               if (at_last) begin
                  idx   <= '0;
                  phase <= PH_DRAW;
               end else begin
                  idx <= idx + IW'(1);
               end
            end
            PH_DRAW: begin
               thr_q <= thr;
               cum_q <= '0;
               phase <= PH_PICK;
            end
            PH_PICK: begin
               cum_q <= cum_n;
               if (cum_n > thr_q || at_last) begin
                  token_q <= idx;
                  done_q  <= 1'b1;
                  phase   <= PH_IDLE;
               end else begin
                  idx <= idx + IW'(1);
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   assign done  = done_q;
   assign token = token_q;

   a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r10_token_range: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (token < IW'(N)));
   a_r11_busy_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_SCAN && !at_last) |=> (phase == PH_SCAN && !done));
   a_r4_arg_nonpositive: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_SUM || phase == PH_PICK) |-> (arg <= 0));
   a_r5_weight_cap: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_SUM) |-> (w <= ONE));
   a_r6_sum_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_SUM) |=> (sum_q >= $past(sum_q)));
   a_r9_thr_below_sum: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_PICK) |-> (thr_q < sum_q));
endmodule

// File: tb/sim_tok_sampler.sv
module sim_tok_sampler;
   localparam int N = 27;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        greedy = 1'b0;
   logic [15:0] inv_temp = 16'd0;
   logic        seed_load = 1'b0;
   logic [31:0] seed = 32'd0;
   logic [4:0]  rd_addr;
   logic [15:0] rd_data;
   logic        done;
   logic [4:0]  token;

   logic signed [15:0] mem [32];
   assign rd_data = mem[rd_addr];

   int checks = 0;
   int fails  = 0;
   logic [31:0] ms = 32'd0;   // model generator state
   int   q_tok[$];
   string q_tag[$];
   logic prev_done = 1'b0;

   always #4 clk = ~clk;

   tok_sampler u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .greedy(greedy),
      .inv_temp(inv_temp), .seed_load(seed_load), .seed(seed),
      .rd_addr(rd_addr), .rd_data(rd_data), .done(done), .token(token));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // monitor: pops the scoreboard on every done, and checks pulse width (R10)
   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_done) chk(!done, "R10 done width", int'(done), 0);
         if (done) begin
            if (q_tok.size() == 0) chk(1'b0, "R11 unexpected done", int'(token), -1);
            else begin
               automatic int e = q_tok.pop_front();
               automatic string t = q_tag.pop_front();
               chk(int'(token) == e, t, int'(token), e);
            end
         end
         prev_done = done;
      end
   end

   function automatic int model_w(int d);
      longint y, n, f;
      if (d < -32768) d = -32768;
      y = (longint'(-d) * 2955) >>> 11;
      n = y >>> 11;
      f = y & 2047;
      return (n >= 16) ? 0 : int'((32768 - 8 * f) >>> n);
   endfunction

   function automatic int model_greedy();
      int b = 0;
      for (int i = 1; i < N; i++) if (mem[i] > mem[b]) b = i;
      return b;
   endfunction

   function automatic int model_sample(input logic [15:0] it, input logic [31:0] src,
                                       output logic [31:0] nst);
      int sc[N];
      int mx;
      longint sum = 0, thr, cum = 0;
      nst = src * 32'd1664525 + 32'd1013904223;
      for (int i = 0; i < N; i++) sc[i] = int'((longint'(mem[i]) * longint'(it)) >>> 11);
      mx = sc[0];
      for (int i = 1; i < N; i++) if (sc[i] > mx) mx = sc[i];
      for (int i = 0; i < N; i++) sum += model_w(sc[i] - mx);
      thr = (longint'(nst[31:16]) * sum) >>> 16;
      for (int i = 0; i < N; i++) begin
         cum += model_w(sc[i] - mx);
         if (cum > thr) return i;
      end
      return N - 1;
   endfunction

   task automatic load_seed(input logic [31:0] s);
      @(negedge clk);
      seed_load = 1'b1; seed = s;
      @(negedge clk);
      seed_load = 1'b0;
      ms = s;
   endtask

   // driver: mode 0 plain, 1 start poke while busy, 2 seed write on draw edge
   task automatic run(input bit g, input logic [15:0] it, input int mode,
                      input logic [31:0] cs, input string tag);
      int e, cnt;
      logic [31:0] nst;
      if (g) e = model_greedy();
      else begin
         e = model_sample(it, (mode == 2) ? cs : ms, nst);
         ms = nst;
      end
      q_tok.push_back(e);
      q_tag.push_back(tag);
      @(negedge clk);
      greedy = g; inv_temp = it; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cnt = 0;
      if (mode == 1) begin
         repeat (9) @(negedge clk);
         start = 1'b1; greedy = ~g; inv_temp = ~it;
         @(negedge clk);
         start = 1'b0; greedy = g; inv_temp = it;
         cnt = 10;
      end else if (mode == 2) begin
         repeat (54) @(negedge clk);
         seed_load = 1'b1; seed = cs;
         @(negedge clk);
         seed_load = 1'b0;
         cnt = 55;
      end
      while (!done) begin
         @(negedge clk);
         cnt++;
      end
      if (g && mode == 0) chk(cnt == N, "R10 greedy latency", cnt, N);
      repeat (3) @(negedge clk);
   endtask

   task automatic fill(input int k, input int amp);
      for (int i = 0; i < 32; i++)
         mem[i] = 16'((((i * 37 + k * 53) % 101) - 50) * amp);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      chk(1'b0, "watchdog", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      fill(0, 41);
      repeat (3) @(negedge clk);
      chk(done == 1'b0, "R1 reset done", int'(done), 0);
      chk(token == 5'd0, "R1 reset token", int'(token), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(done == 1'b0 && token == 5'd0, "R1 after release", int'(token), 0);

      // R2 greedy, distinct pattern then peak
      run(1'b1, 16'd2048, 0, 0, "R2 greedy pattern");
      for (int i = 0; i < N; i++) mem[i] = 16'(i * 10 - 300);
      mem[13] = 16'sd30000;
      run(1'b1, 16'd0, 0, 0, "R2 greedy peak");
      for (int i = 0; i < N; i++) mem[i] = 16'(-20000 + i * 100);
      run(1'b1, 16'd2048, 0, 0, "R2 greedy all negative");

      // R3 ties
      for (int i = 0; i < N; i++) mem[i] = 16'sd100;
      mem[4] = 16'sd900; mem[20] = 16'sd900;
      run(1'b1, 16'd2048, 0, 0, "R3 tie lowest");
      for (int i = 0; i < N; i++) mem[i] = -16'sd5;
      run(1'b1, 16'd2048, 0, 0, "R3 all equal");

      // R7 R8 R9 sampling sequence from a loaded seed
      load_seed(32'd12345);
      for (int k = 1; k <= 6; k++) begin
         fill(k, 41);
         run(1'b0, 16'(k * 700), 0, 0, "R9 sample sequence");
      end

      // R8 greedy runs leave the generator untouched
      run(1'b1, 16'd2048, 0, 0, "R8 greedy between");
      run(1'b1, 16'd2048, 0, 0, "R8 greedy between");
      fill(9, 60);
      run(1'b0, 16'd2048, 0, 0, "R8 sample after greedy");

      // R5 zero temperature: equal weights
      load_seed(32'hDEADBEEF);
      fill(3, 90);
      for (int k = 0; k < 4; k++) run(1'b0, 16'd0, 0, 0, "R5 uniform weights");

      // R4 R5 extreme spread: only the peak has weight
      for (int i = 0; i < N; i++) mem[i] = -16'sd32768;
      mem[9] = 16'sd32767;
      for (int k = 0; k < 3; k++) run(1'b0, 16'hFFFF, 0, 0, "R4 clamp peak only");

      // R9 zero-weight head entries are skipped
      fill(5, 30);
      for (int i = 0; i < 4; i++) mem[i] = -16'sd32768;
      for (int k = 0; k < 4; k++) run(1'b0, 16'h4000, 0, 0, "R9 skip zero weight");

      // R6 all weights at maximum gives the largest total
      for (int i = 0; i < N; i++) mem[i] = 16'sd7;
      run(1'b0, 16'd2048, 0, 0, "R6 full total");

      // R11 start, mode and temperature poked while busy
      fill(7, 50);
      run(1'b0, 16'd3000, 1, 0, "R11 busy sample");
      run(1'b1, 16'd3000, 1, 0, "R11 busy greedy");

      // R12 seed write on the draw edge, then continuation
      fill(11, 45);
      run(1'b0, 16'd2500, 2, 32'h00C0FFEE, "R12 load on draw");
      fill(12, 45);
      run(1'b0, 16'd2500, 0, 0, "R12 continuation");
      run(1'b0, 16'd1024, 2, 32'h13579BDF, "R12 load on draw");

      repeat (5) @(negedge clk);
      chk(q_tok.size() == 0, "R10 results outstanding", q_tok.size(), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule